// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a 32768 Hz timebase enable into a programmable periodic interrupt. A 16-bit cycle counter advances once per timebase enable while the divider-run qualifier is high. A 4-bit rate code picks a power-of-two period. An event fires each time the counter lands on a whole multiple of that period. The tick therefore keeps its phase against the free-running count, however often the code is changed.

Each event is a one-cycle pulse. It also sets a sticky periodic flag, which stays set until the status-read clear input drops it. The interrupt request is the flag gated by the periodic-interrupt-enable bit. The surrounding register file holds the rate code and the enable bit and drives them into this block as plain levels. Each write to those levels takes effect from the next counter advance.

Top module: `perirq_divider`

## Requirements
- R1: After reset the count output is 0 and the pulse, flag and interrupt outputs are all low.
- R2: The count advances by exactly one, wrapping modulo 2^16, on every clock where both `tick32k_en` and `run` are high. Otherwise it holds.
- R3: Rate codes 3 through 15 select a period of 2^(code-1) counter steps, from 4 up to 16384.
- R4: Rate code 1 behaves as code 8 (period 128) and rate code 2 behaves as code 9 (period 256).
- R5: With rate code 0, or with `pie` low, no pulse occurs and the flag is never set.
- R6: `pulse_o` is high for exactly the one cycle in which `cnt_o` first shows a new value that is a multiple of the current period. The pulse tracks the present code after any change of code, so ticks stay aligned to period boundaries of the count.
- R7: While `run` is low, or `tick32k_en` is low, the count holds and no pulse occurs.
- R8: `pflag_o` rises together with each pulse and stays high until a cycle with `flag_clr` high. If a pulse and a clear coincide, the flag stays set.
- R9: `irq_o` equals `pflag_o` AND `pie` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick32k_en | input | 1 | One-cycle enable at the 32768 Hz rate |
| run | input | 1 | Divider-run qualifier; low freezes the counter |
| rate_sel | input | 4 | Rate code; 0 disables, 1 and 2 alias to 8 and 9 |
| pie | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | Status-read strobe that clears the sticky flag |
| cnt_o | output | 16 | Current cycle count |
| pulse_o | output | 1 | One-cycle periodic event |
| pflag_o | output | 1 | Sticky periodic flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default 16-bit counter. It drives the timebase enable on nearly every clock, so even the slowest code (16384 steps) completes two full periods quickly. Sweeping every rate code back to back carries the count past 65535, which exercises the wrap. Further phases with a gated enable, rapid code changes and a permanent clear cover the alignment and flag-priority corners.

// File: rtl/perirq_divider.sv
module perirq_divider #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick32k_en,
  input  logic             run,
  input  logic [3:0]       rate_sel,
  input  logic             pie,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pulse_o,
  output logic             pflag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [3:0]       eff;
  logic [CNT_W-1:0] mask, nxt;
  logic             adv, active, hit;

  always_comb begin
    case (rate_sel)
      4'd1:    eff = 4'd8;
      4'd2:    eff = 4'd9;
      default: eff = rate_sel;
    endcase
  end

  assign mask   = (ONE << (eff - 4'd1)) - ONE;
  assign adv    = tick32k_en & run;
  assign nxt    = cnt_o + ONE;
  assign active = pie & (rate_sel != 4'd0);
  assign hit    = adv & active & ((nxt & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o   <= '0;
      pulse_o <= 1'b0;
      pflag_o <= 1'b0;
    end else begin
      if (adv) cnt_o <= nxt;
      pulse_o <= hit;
      if (hit)           pflag_o <= 1'b1;
      else if (flag_clr) pflag_o <= 1'b0;
    end
  end

  assign irq_o = pflag_o & pie;

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_o));
  // R6
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> ($past(tick32k_en) && $past(run)));
  // R3
  min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (cnt_o[1:0] == 2'b00));
  // R5
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pie || rate_sel == 4'd0) |=> !pulse_o);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pflag_o && !flag_clr) |=> pflag_o);
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> pflag_o);
endmodule

// File: tb/perirq_divider_test.sv
`timescale 1ns/1ps
module perirq_divider_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick32k_en, run, pie, flag_clr;
  logic [3:0]  rate_sel;
  logic [15:0] cnt_o;
  logic        pulse_o, pflag_o, irq_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_cnt;
  logic        m_flag;

  always #4 clk = ~clk;

  perirq_divider uut (
    .clk(clk), .rst_n(rst_n), .tick32k_en(tick32k_en), .run(run),
    .rate_sel(rate_sel), .pie(pie), .flag_clr(flag_clr),
    .cnt_o(cnt_o), .pulse_o(pulse_o), .pflag_o(pflag_o), .irq_o(irq_o)
  );

  function automatic int period_of(input int code);
    int c;
    c = (code == 1) ? 8 : (code == 2) ? 9 : code;
    return 1 << (c - 1);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cnt model %0d", tag, act, exp, m_cnt);
    end
  endtask

  task automatic cyc(input logic en, input logic rn, input int code,
                     input logic pe, input logic clr, input string tag);
    logic hit;
    tick32k_en = en; run = rn; rate_sel = code[3:0]; pie = pe; flag_clr = clr;
    @(posedge clk); #1;
    hit = 1'b0;
    if (en && rn) begin
      m_cnt = m_cnt + 16'd1;
      if (pe && code != 0 && (int'(m_cnt) % period_of(code)) == 0) hit = 1'b1;
    end
    if (hit) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    check("R2 count", int'(cnt_o), int'(m_cnt));
    check(tag, int'(pulse_o), int'(hit));
    check("R8 flag", int'(pflag_o), int'(m_flag));
    check("R9 irq", int'(irq_o), int'(m_flag & pe));
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick32k_en = 1'b1; run = 1'b1; rate_sel = 4'd3; pie = 1'b1; flag_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 count", int'(cnt_o), 0);
    check("R1 pulse", int'(pulse_o), 0);
    check("R1 flag", int'(pflag_o), 0);
    check("R1 irq", int'(irq_o), 0);
    rst_n = 1'b1;
    m_cnt = '0; m_flag = 1'b0;

    // R3 R4 R5: sweep every code, two periods each
    for (int code = 0; code < 16; code++) begin
      int n;
      n = (code == 0) ? 200 : 2 * period_of(code) + 3;
      for (int i = 0; i < n; i++)
        cyc(1'b1, 1'b1, code, 1'b1, (i % 50) == 7,
            (code == 0) ? "R5 code0" : (code <= 2) ? "R4 alias" : "R3 period");
    end

    // R5: enable low
    for (int i = 0; i < 300; i++) cyc(1'b1, 1'b1, 5, 1'b0, 1'b0, "R5 pie off");
    for (int i = 0; i < 20; i++)  cyc(1'b1, 1'b1, 5, 1'b0, 1'b1, "R5 pie off");

    // R7: gated enable and run
    for (int i = 0; i < 400; i++)
      cyc((i % 3) != 0, ((i / 40) % 2) == 0, 3, 1'b1, (i % 29) == 3, "R7 gated");

    // R6: reprogram codes often; ticks stay on period boundaries
    for (int i = 0; i < 900; i++) begin
      int sel;
      int codes[5] = '{3, 4, 5, 6, 1};
      sel = (i / 37) % 5;
      cyc(1'b1, 1'b1, codes[sel], 1'b1, (i % 23) == 11, "R6 realign");
    end

    // R8: clear held high; coincident event keeps flag set
    for (int i = 0; i < 64; i++) cyc(1'b1, 1'b1, 3, 1'b1, 1'b1, "R8 clr vs set");

    // R9: flag set then pie dropped without clear
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, 3, 1'b1, 1'b0, "R9 set");
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, 3, 1'b0, 1'b0, "R9 gated");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule